// File: doc/BRIEF.md
# Single-Register Load/Store Execution Unit

This unit carries out one single-register memory transfer for a 32-bit core. The core's program counter is a 26-bit field, and it lives in the same register as the status flags and the mode bits. The unit is given the low 26 bits of an already-classified instruction and an offset from an external shifter. From these it reads the base and data registers through two register-file read ports, forms the effective address and runs one byte or word access over a valid/ready memory port. It then commits the updated base and the loaded value through a single register write port. The unit also reports the cost of the transfer in sequential, internal and non-sequential cycles.

A transfer starts with a one-cycle `start` pulse while the unit is idle. Both register operands are sampled in that same cycle. The unit then holds the memory request until the memory accepts it. After that it writes the base register (when the write is needed) and then the load destination. It pulses `done` once both writes have been committed. When a load targets the program counter, `flush` pulses together with `done`, so that instruction fetch restarts.

Top module: `ldst_single_unit`

## Requirements
- R1: Instruction fields: bit 25 set takes the offset from `shift_off`, and bit 25 clear takes the zero-extended bits 11:0. Bit 24 selects pre-indexing, bit 23 selects add (set) or subtract (clear), bit 22 selects byte size, bit 21 requests writeback and bit 20 selects load. Bits 19:16 give the base register and bits 15:12 give the data register.
- R2: With pre-indexing, the access address is the base plus or minus the offset. With writeback requested, that address is written to the base register. Without writeback, no base register write occurs.
- R3: When the base is register 15, the base value is bits 25:2 of that register with all other bits cleared. 8 is added to it, except for a pre-indexed transfer that requests writeback.
- R4: With post-indexing, the access uses the unmodified base value. The base is then always written with base plus or minus the offset, whatever bit 21 says, and this write comes before the load write.
- R5: When the base and data registers are the same, a post-indexed transfer makes no base write, and a pre-indexed load with writeback writes only the loaded value.
- R6: Memory is little-endian with four byte lanes. A byte load returns lane address[1:0], zero-extended. A byte store puts the data register's low byte on all four lanes and sets only byte-enable bit address[1:0]. Word accesses set all four enables.
- R7: A word load into register 15 writes memory bits 25:2 and keeps bits 31:26 and 1:0 of the old register 15. Any load into register 15 pulses `flush` in the `done` cycle, and no other transfer does.
- R8: A word store of register 15 puts that register's value plus 8 on the write data.
- R9: The cost outputs hold (sequential, internal, non-sequential) counts from the accepted instruction until the next one. A load costs 1/1/1, a word load into register 15 costs 2/1/2, and a store costs 0/0/2.
- R10: `mem_valid` stays high with a stable address, write flag and data until `mem_ready`. Exactly one access occurs per transfer. A `start` that arrives while busy is ignored. `done` is a single-cycle pulse after the last register write.
- R11: Out of reset the unit is idle, with `busy`, `mem_valid`, `rf_we`, `done` and `flush` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (idle only) |
| insn | input | 26 | Instruction bits 25:0 |
| shift_off | input | 32 | Offset from the external shifter |
| rf_rn_idx | output | 4 | Base register read index |
| rf_rn_data | input | 32 | Base register read data |
| rf_rd_idx | output | 4 | Data register read index |
| rf_rd_data | input | 32 | Data register read data |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_addr | output | 32 | Access address |
| mem_we | output | 1 | 1 for store, 0 for load |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with `mem_ready` |
| rf_we | output | 1 | Register write strobe |
| rf_widx | output | 4 | Register write index |
| rf_wdata | output | 32 | Register write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer complete pulse |
| flush | output | 1 | Restart fetch after a load into register 15 |
| cyc_seq | output | 2 | Sequential cycle count |
| cyc_int | output | 2 | Internal cycle count |
| cyc_nseq | output | 2 | Non-sequential cycle count |

## Verification
The assertions assume three things about the inputs. First, the read ports return the register named by `insn` combinationally in the `start` cycle. Second, `mem_rdata` is meaningful in the handshake cycle. Third, the memory eventually raises `mem_ready`. The bench register-file model answers reads combinationally from its own array and applies writes at the clock edge. Its memory model raises ready after a chosen latency of zero to four cycles. Instructions are driven only for one cycle alongside `start`, as the unit expects, and the one deliberate violation is a second `start` issued while busy, which the unit must ignore.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  localparam int REG_IDX_W = 4;
  localparam int INSN_W    = 26;
  localparam int IMM_W     = 12;

  // field positions within the instruction word
  localparam int POS_REG_OFF = 25;
  localparam int POS_PRE     = 24;
  localparam int POS_UP      = 23;
  localparam int POS_BYTE    = 22;
  localparam int POS_WB      = 21;
  localparam int POS_LOAD    = 20;
  localparam int POS_RN      = 16;
  localparam int POS_RD      = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEM,
    ST_WBASE,
    ST_WLOAD,
    ST_FIN
  } xfer_state_e;

  typedef struct packed {
    logic                 reg_off;
    logic                 pre;
    logic                 up;
    logic                 byte_sz;
    logic                 wb;
    logic                 load;
    logic [REG_IDX_W-1:0] rn;
    logic [REG_IDX_W-1:0] rd;
    logic [IMM_W-1:0]     imm;
  } xfer_op_t;

  function automatic xfer_op_t decode_op(input logic [INSN_W-1:0] w);
    xfer_op_t o;
    o.reg_off = w[POS_REG_OFF];
    o.pre     = w[POS_PRE];
    o.up      = w[POS_UP];
    o.byte_sz = w[POS_BYTE];
    o.wb      = w[POS_WB];
    o.load    = w[POS_LOAD];
    o.rn      = w[POS_RN +: REG_IDX_W];
    o.rd      = w[POS_RD +: REG_IDX_W];
    o.imm     = w[IMM_W-1:0];
    return o;
  endfunction

endpackage

// File: rtl/ldst_agu.sv
module ldst_agu import ldst_pkg::*; #(
  parameter int XLEN       = 32,
  parameter int PC_FIELD_W = 26,
  parameter int PC_BIAS    = 8
) (
  input  logic                 pre,
  input  logic                 up,
  input  logic                 wb,
  input  logic [REG_IDX_W-1:0] rn_idx,
  input  logic [XLEN-1:0]      rn_val,
  input  logic [XLEN-1:0]      offset,
  output logic [XLEN-1:0]      ea,
  output logic [XLEN-1:0]      base_next
);

  localparam logic [REG_IDX_W-1:0] PC_IDX = REG_IDX_W'((1 << REG_IDX_W) - 1);
  localparam logic [XLEN-1:0] FIELD_ONES = {{(XLEN-PC_FIELD_W){1'b0}}, {PC_FIELD_W{1'b1}}};
  localparam logic [XLEN-1:0] ADDR_MASK  = FIELD_ONES & ~XLEN'(3);

  logic [XLEN-1:0] base_eff;
  logic [XLEN-1:0] pc_adj;
  logic [XLEN-1:0] moved;

  always_comb begin
    pc_adj   = (pre && wb) ? '0 : XLEN'(PC_BIAS);
    base_eff = (rn_idx == PC_IDX) ? ((rn_val & ADDR_MASK) + pc_adj) : rn_val;
    moved    = up ? (base_eff + offset) : (base_eff - offset);
    ea        = pre ? moved : base_eff;
    base_next = moved;
  end

endmodule

// File: rtl/ldst_lane.sv
module ldst_lane #(
  parameter int XLEN       = 32,
  parameter int PC_FIELD_W = 26,
  parameter int PC_BIAS    = 8,
  localparam int NLANE     = XLEN / 8,
  localparam int LANE_W    = $clog2(NLANE)
) (
  input  logic              byte_sz,
  input  logic              src_is_pc,
  input  logic [XLEN-1:0]   src_val,
  input  logic [LANE_W-1:0] lane_sel,
  input  logic [XLEN-1:0]   rdata,
  input  logic              merge_pc,
  output logic [XLEN-1:0]   wdata,
  output logic [NLANE-1:0]  be,
  output logic [XLEN-1:0]   ldata
);

  localparam logic [XLEN-1:0] FIELD_ONES = {{(XLEN-PC_FIELD_W){1'b0}}, {PC_FIELD_W{1'b1}}};
  localparam logic [XLEN-1:0] ADDR_MASK  = FIELD_ONES & ~XLEN'(3);

  logic [7:0] lane_b [NLANE];
  logic [7:0] picked;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_b[g] = rdata[8*g +: 8];
  end

  assign picked = lane_b[lane_sel];

  always_comb begin
    if (byte_sz) begin
      wdata = {NLANE{src_val[7:0]}};
      be    = NLANE'(1) << lane_sel;
      ldata = XLEN'(picked);
    end else begin
      wdata = src_is_pc ? (src_val + XLEN'(PC_BIAS)) : src_val;
      be    = '1;
      ldata = merge_pc ? ((rdata & ADDR_MASK) | (src_val & ~ADDR_MASK)) : rdata;
    end
  end

endmodule

// File: rtl/ldst_cost.sv
module ldst_cost #(
  parameter int CNT_W = 2
) (
  input  logic             load,
  input  logic             byte_sz,
  input  logic             dest_pc,
  output logic [CNT_W-1:0] n_seq,
  output logic [CNT_W-1:0] n_int,
  output logic [CNT_W-1:0] n_nseq
);

  always_comb begin
    if (load) begin
      n_seq  = CNT_W'(1);
      n_int  = CNT_W'(1);
      n_nseq = CNT_W'(1);
      if (!byte_sz && dest_pc) begin
        n_seq  = CNT_W'(2);
        n_nseq = CNT_W'(2);
      end
    end else begin
      n_seq  = '0;
      n_int  = '0;
      n_nseq = CNT_W'(2);
    end
  end

endmodule

// File: rtl/ldst_single_unit.sv
module ldst_single_unit import ldst_pkg::*; #(
  parameter int XLEN       = 32,
  parameter int PC_FIELD_W = 26,
  parameter int PC_BIAS    = 8,
  parameter int CNT_W      = 2,
  localparam int NLANE     = XLEN / 8,
  localparam int LANE_W    = $clog2(NLANE)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [INSN_W-1:0]    insn,
  input  logic [XLEN-1:0]      shift_off,
  output logic [REG_IDX_W-1:0] rf_rn_idx,
  input  logic [XLEN-1:0]      rf_rn_data,
  output logic [REG_IDX_W-1:0] rf_rd_idx,
  input  logic [XLEN-1:0]      rf_rd_data,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  output logic [XLEN-1:0]      mem_addr,
  output logic                 mem_we,
  output logic [NLANE-1:0]     mem_be,
  output logic [XLEN-1:0]      mem_wdata,
  input  logic [XLEN-1:0]      mem_rdata,
  output logic                 rf_we,
  output logic [REG_IDX_W-1:0] rf_widx,
  output logic [XLEN-1:0]      rf_wdata,
  output logic                 busy,
  output logic                 done,
  output logic                 flush,
  output logic [CNT_W-1:0]     cyc_seq,
  output logic [CNT_W-1:0]     cyc_int,
  output logic [CNT_W-1:0]     cyc_nseq
);

  localparam logic [REG_IDX_W-1:0] PC_IDX = REG_IDX_W'((1 << REG_IDX_W) - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // decode and operand formation in the start cycle
  xfer_op_t        op;
  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] ea_d;
  logic [XLEN-1:0] base_next_d;
  logic            base_wr_d;
  logic            dest_pc_d;
  logic [CNT_W-1:0] seq_d, int_d, nseq_d;

  assign op        = decode_op(insn);
  assign rf_rn_idx = op.rn;
  assign rf_rd_idx = op.rd;
  assign offset    = op.reg_off ? shift_off : XLEN'(op.imm);
  assign dest_pc_d = (op.rd == PC_IDX);

  // base write is skipped when it would collide with the data register
  assign base_wr_d = (op.pre ? op.wb : 1'b1) && !((op.rn == op.rd) && (op.load || !op.pre));

  ldst_agu #(
    .XLEN(XLEN), .PC_FIELD_W(PC_FIELD_W), .PC_BIAS(PC_BIAS)
  ) agu_i (
    .pre(op.pre), .up(op.up), .wb(op.wb), .rn_idx(op.rn), .rn_val(rf_rn_data),
    .offset(offset), .ea(ea_d), .base_next(base_next_d)
  );

  ldst_cost #(.CNT_W(CNT_W)) cost_i (
    .load(op.load), .byte_sz(op.byte_sz), .dest_pc(dest_pc_d),
    .n_seq(seq_d), .n_int(int_d), .n_nseq(nseq_d)
  );

  // state
  xfer_state_e          state_q, state_d;
  logic                 accept, mem_hs;
  logic [XLEN-1:0]      ea_q, base_next_q, rdval_q, ldata_q;
  logic [REG_IDX_W-1:0] rn_q, rd_q;
  logic                 byte_q, load_q, base_wr_q, pc_word_q, flush_q;
  logic [XLEN-1:0]      ldata_d;

  assign accept = start && (state_q == ST_IDLE);
  assign mem_hs = (state_q == ST_MEM) && mem_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_MEM;
      ST_MEM:   if (mem_ready) state_d = base_wr_q ? ST_WBASE : (load_q ? ST_WLOAD : ST_FIN);
      ST_WBASE: state_d = load_q ? ST_WLOAD : ST_FIN;
      ST_WLOAD: state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // operand capture, enabled by accept
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_q        <= '0;
      base_next_q <= '0;
      rdval_q     <= '0;
      rn_q        <= '0;
      rd_q        <= '0;
      byte_q      <= 1'b0;
      load_q      <= 1'b0;
      base_wr_q   <= 1'b0;
      pc_word_q   <= 1'b0;
      flush_q     <= 1'b0;
      cyc_seq     <= '0;
      cyc_int     <= '0;
      cyc_nseq    <= '0;
    end else if (accept) begin
      ea_q        <= ea_d;
      base_next_q <= base_next_d;
      rdval_q     <= rf_rd_data;
      rn_q        <= op.rn;
      rd_q        <= op.rd;
      byte_q      <= op.byte_sz;
      load_q      <= op.load;
      base_wr_q   <= base_wr_d;
      pc_word_q   <= op.load && !op.byte_sz && dest_pc_d;
      flush_q     <= op.load && dest_pc_d;
      cyc_seq     <= seq_d;
      cyc_int     <= int_d;
      cyc_nseq    <= nseq_d;
    end
  end

  // lane formatting from captured operands
  ldst_lane #(
    .XLEN(XLEN), .PC_FIELD_W(PC_FIELD_W), .PC_BIAS(PC_BIAS)
  ) lane_i (
    .byte_sz(byte_q), .src_is_pc(rd_q == PC_IDX), .src_val(rdval_q),
    .lane_sel(ea_q[LANE_W-1:0]), .rdata(mem_rdata), .merge_pc(pc_word_q),
    .wdata(mem_wdata), .be(mem_be), .ldata(ldata_d)
  );

  // load data capture, enabled by the handshake
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     ldata_q <= '0;
    else if (mem_hs) ldata_q <= ldata_d;
  end

  // outputs
  assign mem_valid = (state_q == ST_MEM);
  assign mem_addr  = ea_q;
  assign mem_we    = !load_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign flush     = done && flush_q;

  always_comb begin
    rf_we    = 1'b0;
    rf_widx  = rn_q;
    rf_wdata = base_next_q;
    if (state_q == ST_WBASE) begin
      rf_we = 1'b1;
    end else if (state_q == ST_WLOAD) begin
      rf_we    = 1'b1;
      rf_widx  = rd_q;
      rf_wdata = ldata_q;
    end
  end

  // checks
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);
  a_r7_flush_in_done: assert property (@(posedge clk) disable iff (!rst_ni)
    flush |-> done);
  a_r6_byte_onehot: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_valid && (mem_be != '1) |-> $countones(mem_be) == 1);
  a_r4_write_after_access: assert property (@(posedge clk) disable iff (!rst_ni)
    rf_we |-> busy && !mem_valid);
  a_r9_cost_held: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |=> $stable(cyc_seq) && $stable(cyc_int) && $stable(cyc_nseq));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> !rf_we && !mem_valid && !done);

endmodule

// File: tb/ldst_single_unit_tb.sv
module ldst_single_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [25:0] insn;
  logic [31:0] shift_off;
  logic [3:0]  rf_rn_idx, rf_rd_idx, rf_widx;
  logic [31:0] rf_rn_data, rf_rd_data, rf_wdata;
  logic        mem_valid, mem_ready, mem_we, rf_we, busy, done, flush;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic [1:0]  cyc_seq, cyc_int, cyc_nseq;

  always #2.5 clk = ~clk;

  ldst_single_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .shift_off(shift_off),
    .rf_rn_idx(rf_rn_idx), .rf_rn_data(rf_rn_data), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
    .busy(busy), .done(done), .flush(flush),
    .cyc_seq(cyc_seq), .cyc_int(cyc_int), .cyc_nseq(cyc_nseq)
  );

  // register file and memory models
  logic [31:0] rf [16];
  logic        pl_en;
  logic [3:0]  pl_idx;
  logic [31:0] pl_val;
  int          lat;
  int          wcnt;
  logic [31:0] mem_word;
  int          wr_n, tx_n;
  logic [3:0]  wr_idx [4];
  logic [31:0] wr_dat [4];
  logic [31:0] tx_addr, tx_wd;
  logic [3:0]  tx_be;
  logic        tx_we;

  assign rf_rn_data = rf[rf_rn_idx];
  assign rf_rd_data = rf[rf_rd_idx];
  assign mem_rdata  = mem_word;
  assign mem_ready  = mem_valid && (wcnt >= lat);

  always @(posedge clk) begin
    if (pl_en) rf[pl_idx] <= pl_val;
    if (rf_we) rf[rf_widx] <= rf_wdata;
    if (mem_valid && mem_ready) wcnt <= 0;
    else if (mem_valid)         wcnt <= wcnt + 1;
    if (start && !busy) begin
      wr_n <= 0;
      tx_n <= 0;
    end else begin
      if (rf_we && wr_n < 4) begin
        wr_idx[wr_n] <= rf_widx;
        wr_dat[wr_n] <= rf_wdata;
        wr_n <= wr_n + 1;
      end
      if (mem_valid && mem_ready) begin
        tx_n    <= tx_n + 1;
        tx_addr <= mem_addr;
        tx_wd   <= mem_wdata;
        tx_be   <= mem_be;
        tx_we   <= mem_we;
      end
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  logic got_flush;
  logic all_done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [25:0] mk(input logic i, p, u, b, w, l,
                                     input logic [3:0] rn, rd, input logic [11:0] imm);
    return {i, p, u, b, w, l, rn, rd, imm};
  endfunction

  task automatic preload(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    pl_en = 1'b1; pl_idx = idx; pl_val = val;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  task automatic run(input logic [25:0] ins, input logic [31:0] so, input int l);
    bit seen = 0;
    @(negedge clk);
    insn = ins; shift_off = so; lat = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 60 && !seen; k++) begin
      if (done) begin seen = 1; got_flush = flush; end
      else @(negedge clk);
    end
    chk("R10", "done seen", 32'(seen), 32'd1);
  endtask

  task automatic t_reset;
    chk("R11", "busy", 32'(busy), 0);
    chk("R11", "mem_valid", 32'(mem_valid), 0);
    chk("R11", "rf_we", 32'(rf_we), 0);
    chk("R11", "done", 32'(done), 0);
    chk("R11", "flush", 32'(flush), 0);
  endtask

  task automatic t_pre_load;  // R2 up, no writeback; R9 load cost
    mem_word = 32'h11223344;
    run(mk(0,1,1,0,0,1,4'd1,4'd4,12'h010), 32'h0, 1);
    chk("R2", "addr", tx_addr, 32'h1010);
    chk("R2", "writes", wr_n, 1);
    chk("R2", "r4", rf[4], 32'h11223344);
    chk("R7", "no flush", 32'(got_flush), 0);
    chk("R9", "cost", {26'd0, cyc_seq, cyc_int, cyc_nseq}, 32'b010101);
  endtask

  task automatic t_pre_wb_store;  // R2 down with writeback, R9 store cost
    run(mk(0,1,0,0,1,0,4'd2,4'd3,12'h020), 32'h0, 0);
    chk("R2", "addr", tx_addr, 32'h1FE0);
    chk("R2", "we", 32'(tx_we), 1);
    chk("R2", "wdata", tx_wd, 32'hDEADBEEF);
    chk("R6", "word be", 32'(tx_be), 32'hF);
    chk("R2", "r2 wb", rf[2], 32'h1FE0);
    chk("R2", "writes", wr_n, 1);
    chk("R9", "cost", {26'd0, cyc_seq, cyc_int, cyc_nseq}, 32'b000010);
  endtask

  task automatic t_post_shift_load;  // R1 shifter offset, R4 post-index
    mem_word = 32'h55667788;
    run(mk(1,0,0,0,0,1,4'd1,4'd5,12'h004), 32'h100, 3);
    chk("R4", "addr", tx_addr, 32'h1000);
    chk("R1", "base uses shifter", rf[1], 32'h0F00);
    chk("R4", "order base first", 32'(wr_idx[0]), 1);
    chk("R4", "then load", 32'(wr_idx[1]), 5);
    chk("R4", "r5", rf[5], 32'h55667788);
  endtask

  task automatic t_post_byte_store;  // R4 with W set, R6 byte store
    run(mk(0,0,1,1,1,0,4'd2,4'd3,12'h004), 32'hFFFF, 2);
    chk("R6", "addr", tx_addr, 32'h1FE0);
    chk("R6", "byte be", 32'(tx_be), 32'h1);
    chk("R6", "byte wdata", tx_wd, 32'hEFEFEFEF);
    chk("R4", "r2 post", rf[2], 32'h1FE4);
  endtask

  task automatic t_byte_load;  // R6 lane 2 zero-extend
    mem_word = 32'hA1B2C3D4;
    run(mk(0,1,1,1,0,1,4'd2,4'd6,12'h002), 32'h0, 0);
    chk("R6", "addr", tx_addr, 32'h1FE6);
    chk("R6", "be lane2", 32'(tx_be), 32'h4);
    chk("R6", "r6 zext", rf[6], 32'h000000B2);
  endtask

  task automatic t_pc_base;  // R3
    preload(4'd15, 32'hAC001237);
    run(mk(0,1,1,0,0,1,4'd15,4'd7,12'h004), 32'h0, 1);
    chk("R3", "pre no wb", tx_addr, 32'h1240);
    run(mk(0,1,1,0,1,0,4'd15,4'd3,12'h010), 32'h0, 1);
    chk("R3", "pre wb addr", tx_addr, 32'h1244);
    chk("R3", "pre wb r15", rf[15], 32'h1244);
    preload(4'd15, 32'hAC001237);
    run(mk(0,0,1,0,0,1,4'd15,4'd8,12'h004), 32'h0, 1);
    chk("R3", "post addr", tx_addr, 32'h123C);
    chk("R3", "post r15", rf[15], 32'h1240);
  endtask

  task automatic t_same_reg;  // R5
    preload(4'd1, 32'h3000);
    mem_word = 32'h0BADF00D;
    run(mk(0,0,1,0,0,1,4'd1,4'd1,12'h008), 32'h0, 1);
    chk("R5", "post addr", tx_addr, 32'h3000);
    chk("R5", "post writes", wr_n, 1);
    chk("R5", "post r1", rf[1], 32'h0BADF00D);
    preload(4'd2, 32'h4000);
    mem_word = 32'hCAFE0001;
    run(mk(0,1,1,0,1,1,4'd2,4'd2,12'h004), 32'h0, 0);
    chk("R5", "pre addr", tx_addr, 32'h4004);
    chk("R5", "pre writes", wr_n, 1);
    chk("R5", "pre r2", rf[2], 32'hCAFE0001);
  endtask

  task automatic t_pc_load;  // R7, R9
    preload(4'd15, 32'hAC001237);
    preload(4'd1, 32'h5000);
    mem_word = 32'hF0F0F0F1;
    run(mk(0,1,1,0,0,1,4'd1,4'd15,12'h000), 32'h0, 2);
    chk("R7", "merged r15", rf[15], 32'hACF0F0F3);
    chk("R7", "flush", 32'(got_flush), 1);
    chk("R9", "pc load cost", {26'd0, cyc_seq, cyc_int, cyc_nseq}, 32'b100110);
  endtask

  task automatic t_pc_store;  // R8
    preload(4'd15, 32'hAC001237);
    run(mk(0,1,1,0,0,0,4'd1,4'd15,12'h000), 32'h0, 0);
    chk("R8", "pc+8", tx_wd, 32'hAC00123F);
    chk("R8", "addr", tx_addr, 32'h5000);
    chk("R7", "store no flush", 32'(got_flush), 0);
  endtask

  task automatic t_busy_ignore;  // R10
    bit seen = 0;
    preload(4'd9, 32'h7000);
    mem_word = 32'h12345678;
    @(negedge clk);
    insn = mk(0,1,1,0,0,1,4'd9,4'd10,12'h000); lat = 4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    insn = mk(0,1,1,0,1,0,4'd9,4'd3,12'h040); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 60 && !seen; k++) begin
      if (done) seen = 1; else @(negedge clk);
    end
    chk("R10", "done", 32'(seen), 1);
    chk("R10", "one access", tx_n, 1);
    chk("R10", "load kept", 32'(tx_we), 0);
    chk("R10", "r10", rf[10], 32'h12345678);
    chk("R10", "r9 untouched", rf[9], 32'h7000);
    @(negedge clk);
    chk("R10", "done one cycle", 32'(done), 0);
    repeat (6) @(negedge clk);
    chk("R10", "stays idle", 32'(busy), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; insn = '0; shift_off = '0;
    pl_en = 1'b0; pl_idx = '0; pl_val = '0; lat = 0; wcnt = 0; mem_word = '0;
    wr_n = 0; tx_n = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    preload(4'd1, 32'h1000);
    preload(4'd2, 32'h2000);
    preload(4'd3, 32'hDEADBEEF);
    t_pre_load;
    t_pre_wb_store;
    t_post_shift_load;
    t_post_byte_store;
    t_byte_load;
    t_pc_base;
    t_same_reg;
    t_pc_load;
    t_pc_store;
    t_busy_ignore;
    all_done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!all_done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule